// File: doc/BRIEF.md
# Card Host Interrupt Status Controller

This block gathers the event flags of a memory-card host and turns them into a single interrupt request. Each event arrives as a one-cycle pulse from the card protocol engine: command done, response timeout, data timeout, CRC errors, block done, multi-block done, auto-stop done, device inserted and the SDIO interrupt. The block latches each one into a sticky bit of a byte-wide status register. Software clears a bit by writing 1 to it. Per-bit mask registers select which latched bits may raise the interrupt, and a global enable gates the line as a whole.

The same status bytes also show live levels: the write-protect pin, the two card-detect sources and the two busy flags of the protocol engine. The pins pass through a two-flop synchroniser. A configuration register holds the global interrupt enable, the choice of card-detect source, the detect polarity, the abort-on-CRC option and the block length minus one. Every edge of the selected detect source records a detect-change event. The register bus is byte-addressed. Writes take effect on the clock edge, and reads are combinational.

Top module: `card_irq_status`

Register offsets: 0 status A, 1 status B, 2 status C, 4 mask A, 5 mask B, 8 config low byte, 9 config high byte. Any other offset reads 0.

## Requirements
- R1: After reset the masks, the config register and the clock-freeze control bit are 0, every event bit is 0 and `irq` is low.
- R2: A one-cycle event pulse sets its status bit at the next clock edge, and the bit stays set until it is cleared. Status A: bit 4 multi-block done, bit 5 block done, bit 7 device inserted. Status B: bit 0 SDIO interrupt, bit 1 command done, bit 2 response timeout, bit 3 auto-stop done, bit 4 data timeout, bit 5 response CRC error, bit 6 read CRC error, bit 7 write CRC error.
- R3: Writing a 1 to an event bit of status A or status B clears it. Writing a 0 leaves it unchanged, and writing 0xFF clears every event bit of the byte.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit is left set.
- R5: Status A bit 1 (write protect), bit 2 (detect on DATA3) and bit 3 (detect on the GPI pin) show their pins two clock edges after the pin changes, and writes have no effect on them.
- R6: Mask A keeps only bits 4–7 and mask B keeps only bits 1–7. The other mask bits read 0.
- R7: `irq` is high exactly when config bit 15 is set and some bit of status A or status B is set together with the same bit of its mask. Status B bit 0 never raises `irq`.
- R8: Config bits are: 15 global interrupt enable, 14 DATA3 detect select, 13 GPI detect select, 12 detect active-high, 11 abort on CRC error (`crc_abort_en`), and 10:0 block length minus one (`blk_len_m1`). All of them read back as written.
- R9: Status C shows `cmd_busy` at bit 4 and `data_busy` at bit 5. Bit 7 is a read/write control that drives `clk_freeze_en`. The other bits read 0, and writes do not change the busy bits.
- R10: Every edge of the selected detect source sets status A bit 6 three clock edges after the pin changes. An edge on the source that is not selected sets nothing.
- R11: `card_present` equals the selected synchronised detect level when config bit 12 is 1, and its inverse when bit 12 is 0. GPI takes priority when both selects are set, and `card_present` is 0 when neither is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ev_mblk_done | input | 1 | Multi-block transfer done pulse |
| ev_blk_done | input | 1 | Block transfer done pulse |
| ev_dev_insert | input | 1 | Device inserted pulse |
| ev_sdio | input | 1 | SDIO card interrupt pulse |
| ev_cmd_done | input | 1 | Command/response done pulse |
| ev_rsp_timeout | input | 1 | Response timeout pulse |
| ev_autostop | input | 1 | Auto-stop done pulse |
| ev_data_timeout | input | 1 | Data timeout pulse |
| ev_rsp_crc | input | 1 | Response CRC error pulse |
| ev_rd_crc | input | 1 | Read data CRC error pulse |
| ev_wr_crc | input | 1 | Write data CRC error pulse |
| pin_wp | input | 1 | Write-protect pin, asynchronous |
| pin_cd_dat3 | input | 1 | DATA3 card-detect pin, asynchronous |
| pin_cd_gpi | input | 1 | Dedicated card-detect pin, asynchronous |
| cmd_busy | input | 1 | Command path busy level |
| data_busy | input | 1 | Data path busy level |
| irq | output | 1 | Interrupt request |
| card_present | output | 1 | Polarity-corrected card-detect level |
| blk_len_m1 | output | BLEN_W | Block length minus one |
| crc_abort_en | output | 1 | Abort on CRC error |
| clk_freeze_en | output | 1 | Automatic clock-freeze enable |

## Verification
A new event and a write-1-to-clear of the same status bit can land in the same clock cycle. The bench provokes this by driving the command-done pulse and a status B write of 0x02 on the same falling edge, so both are sampled at one rising edge. The bit must read back as set afterwards. A second collision pairs a 0xFF clear of status A with a rising write-protect pin, and the level bit must survive the clear. Detect-change edges and unselected-source edges are timed cycle by cycle against the synchroniser depth.

// File: rtl/cardirq_pkg.sv
package cardirq_pkg;
    localparam int BYTE_W = 8;

    // register byte offsets
    localparam int OFF_STA  = 0;
    localparam int OFF_STB  = 1;
    localparam int OFF_STC  = 2;
    localparam int OFF_MSKA = 4;
    localparam int OFF_MSKB = 5;
    localparam int OFF_CFGL = 8;
    localparam int OFF_CFGH = 9;

    // status A bit positions
    localparam int STA_WP    = 1;
    localparam int STA_CD_D3 = 2;
    localparam int STA_CD_GP = 3;
    localparam int STA_MBLK  = 4;
    localparam int STA_BLK   = 5;
    localparam int STA_CDCHG = 6;
    localparam int STA_INS   = 7;

    // config register bit positions
    localparam int CFG_GIE   = 15;
    localparam int CFG_SELD3 = 14;
    localparam int CFG_SELGP = 13;
    localparam int CFG_POLHI = 12;
    localparam int CFG_CRCAB = 11;

    localparam logic [BYTE_W-1:0] STICKY_A = 8'hF0;
    localparam logic [BYTE_W-1:0] STICKY_B = 8'hFF;
    localparam logic [BYTE_W-1:0] MASKA_WR = 8'hF0;
    localparam logic [BYTE_W-1:0] MASKB_WR = 8'hFE;

    typedef struct packed {
        logic [BYTE_W-1:0] mask_a;
        logic [BYTE_W-1:0] mask_b;
        logic [15:0]       cfg;
        logic              freeze;
        logic              cd_prev;
    } ctl_t;
endpackage

// File: rtl/cardirq_sync.sv
module cardirq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cardirq_evt_bank.sv
module cardirq_evt_bank #(
    parameter int           W      = 8,
    parameter logic [W-1:0] STICKY = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] q
);
    logic [W-1:0] evt_d, evt_q;

    // a new event overrides a simultaneous clear
    always_comb begin
        evt_d = ((evt_q & ~clr) | ev) & STICKY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign q = (evt_q & STICKY) | (lvl & ~STICKY);

    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            if (STICKY[i]) begin : g_sticky
                a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
                    ev[i] |=> q[i]);
                a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr[i] && !ev[i]) |=> !q[i]);
                a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
                    (q[i] && !clr[i]) |=> q[i]);
            end
        end
    endgenerate
endmodule

// File: rtl/card_irq_status.sv
module card_irq_status
    import cardirq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BLEN_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_mblk_done,
    input  logic              ev_blk_done,
    input  logic              ev_dev_insert,
    input  logic              ev_sdio,
    input  logic              ev_cmd_done,
    input  logic              ev_rsp_timeout,
    input  logic              ev_autostop,
    input  logic              ev_data_timeout,
    input  logic              ev_rsp_crc,
    input  logic              ev_rd_crc,
    input  logic              ev_wr_crc,
    input  logic              pin_wp,
    input  logic              pin_cd_dat3,
    input  logic              pin_cd_gpi,
    input  logic              cmd_busy,
    input  logic              data_busy,
    output logic              irq,
    output logic              card_present,
    output logic [BLEN_W-1:0] blk_len_m1,
    output logic              crc_abort_en,
    output logic              clk_freeze_en
);
    localparam logic [15:0] CFG_WMASK = 16'hF800 | 16'((32'h1 << BLEN_W) - 1);

    ctl_t r_d, r_q;

    logic [2:0] pin_s;
    logic       wp_s, d3_s, gp_s;

    cardirq_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_cd_gpi, pin_cd_dat3, pin_wp}),
        .dout (pin_s)
    );
    assign {gp_s, d3_s, wp_s} = pin_s;

    // address decode
    logic hit_sta, hit_stb, hit_stc, hit_mska, hit_mskb, hit_cfgl, hit_cfgh;
    always_comb begin
        hit_sta  = bus_addr == ADDR_W'(OFF_STA);
        hit_stb  = bus_addr == ADDR_W'(OFF_STB);
        hit_stc  = bus_addr == ADDR_W'(OFF_STC);
        hit_mska = bus_addr == ADDR_W'(OFF_MSKA);
        hit_mskb = bus_addr == ADDR_W'(OFF_MSKB);
        hit_cfgl = bus_addr == ADDR_W'(OFF_CFGL);
        hit_cfgh = bus_addr == ADDR_W'(OFF_CFGH);
    end

    // card-detect source selection
    logic src_valid, sel_lvl, cd_change;
    always_comb begin
        src_valid = r_q.cfg[CFG_SELGP] | r_q.cfg[CFG_SELD3];
        if (r_q.cfg[CFG_SELGP])      sel_lvl = gp_s;
        else if (r_q.cfg[CFG_SELD3]) sel_lvl = d3_s;
        else                         sel_lvl = 1'b0;
        cd_change    = src_valid && (sel_lvl != r_q.cd_prev);
        card_present = src_valid && (r_q.cfg[CFG_POLHI] ? sel_lvl : ~sel_lvl);
    end

    // status banks
    logic [7:0] ev_a, ev_b, clr_a, clr_b, lvl_a, st_a, st_b, st_c;
    always_comb begin
        ev_a = '0;
        ev_a[STA_MBLK]  = ev_mblk_done;
        ev_a[STA_BLK]   = ev_blk_done;
        ev_a[STA_CDCHG] = cd_change;
        ev_a[STA_INS]   = ev_dev_insert;
        ev_b = {ev_wr_crc, ev_rd_crc, ev_rsp_crc, ev_data_timeout,
                ev_autostop, ev_rsp_timeout, ev_cmd_done, ev_sdio};
        lvl_a = '0;
        lvl_a[STA_WP]    = wp_s;
        lvl_a[STA_CD_D3] = d3_s;
        lvl_a[STA_CD_GP] = gp_s;
        clr_a = (bus_we && hit_sta) ? bus_wdata : 8'h00;
        clr_b = (bus_we && hit_stb) ? bus_wdata : 8'h00;
    end

    cardirq_evt_bank #(.W(8), .STICKY(STICKY_A)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .ev(ev_a), .clr(clr_a), .lvl(lvl_a), .q(st_a)
    );
    cardirq_evt_bank #(.W(8), .STICKY(STICKY_B)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .ev(ev_b), .clr(clr_b), .lvl(8'h00), .q(st_b)
    );

    // next-state logic for control registers
    always_comb begin
        r_d = r_q;
        r_d.cd_prev = sel_lvl;
        if (bus_we) begin
            if (hit_mska) r_d.mask_a = bus_wdata & MASKA_WR;
            if (hit_mskb) r_d.mask_b = bus_wdata & MASKB_WR;
            if (hit_cfgl) r_d.cfg[7:0]  = bus_wdata & CFG_WMASK[7:0];
            if (hit_cfgh) r_d.cfg[15:8] = bus_wdata & CFG_WMASK[15:8];
            if (hit_stc)  r_d.freeze = bus_wdata[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux and outputs
    always_comb begin
        st_c = {r_q.freeze, 1'b0, data_busy, cmd_busy, 4'b0000};
        bus_rdata = 8'h00;
        if (hit_sta)  bus_rdata = st_a;
        if (hit_stb)  bus_rdata = st_b;
        if (hit_stc)  bus_rdata = st_c;
        if (hit_mska) bus_rdata = r_q.mask_a;
        if (hit_mskb) bus_rdata = r_q.mask_b;
        if (hit_cfgl) bus_rdata = r_q.cfg[7:0];
        if (hit_cfgh) bus_rdata = r_q.cfg[15:8];
        irq = r_q.cfg[CFG_GIE] && (|((st_a & r_q.mask_a) | (st_b & r_q.mask_b)));
    end

    assign blk_len_m1    = r_q.cfg[BLEN_W-1:0];
    assign crc_abort_en  = r_q.cfg[CFG_CRCAB];
    assign clk_freeze_en = r_q.freeze;

    a_r10_edge_records_change: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && (sel_lvl != r_q.cd_prev)) |=> st_a[STA_CDCHG]);
    a_r9_freeze_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && hit_stc) |=> $stable(clk_freeze_en));
    a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (hit_cfgl || hit_cfgh)) |=> ($stable(blk_len_m1) && $stable(crc_abort_en)));
    a_r7_sdio_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_a & r_q.mask_a) == 8'h00 && st_b == 8'h01) |-> !irq);
endmodule

// File: tb/sim_card_irq_status.sv
module sim_card_irq_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [10:0] ev = '0;
    logic       pin_wp = 0, pin_cd_dat3 = 0, pin_cd_gpi = 0;
    logic       cmd_busy = 0, data_busy = 0;
    logic       irq, card_present, crc_abort_en, clk_freeze_en;
    logic [10:0] blk_len_m1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_mblk_done(ev[0]), .ev_blk_done(ev[1]), .ev_dev_insert(ev[2]),
        .ev_sdio(ev[3]), .ev_cmd_done(ev[4]), .ev_rsp_timeout(ev[5]),
        .ev_autostop(ev[6]), .ev_data_timeout(ev[7]), .ev_rsp_crc(ev[8]),
        .ev_rd_crc(ev[9]), .ev_wr_crc(ev[10]),
        .pin_wp(pin_wp), .pin_cd_dat3(pin_cd_dat3), .pin_cd_gpi(pin_cd_gpi),
        .cmd_busy(cmd_busy), .data_busy(data_busy),
        .irq(irq), .card_present(card_present), .blk_len_m1(blk_len_m1),
        .crc_abort_en(crc_abort_en), .clk_freeze_en(clk_freeze_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        ev[idx] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        foreach (v[i]) v[i] = 1'b0;
        rd(0, v); chk("R1 status A", v, 0);
        rd(1, v); chk("R1 status B", v, 0);
        rd(2, v); chk("R1 status C", v, 0);
        rd(4, v); chk("R1 mask A", v, 0);
        rd(5, v); chk("R1 mask B", v, 0);
        rd(8, v); chk("R1 cfg low", v, 0);
        rd(9, v); chk("R1 cfg high", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_events();
        logic [7:0] v;
        int ra [11] = '{0,0,0,1,1,1,1,1,1,1,1};
        int bp [11] = '{4,5,7,0,1,2,3,4,5,6,7};
        for (int i = 0; i < 11; i++) begin
            pulse(i);
            repeat (2) @(negedge clk);
            rd(4'(ra[i]), v);
            chk($sformatf("R2 event %0d sticky", i), v, 16'(1 << bp[i]));
            wr(4'(ra[i]), 8'hFF);
            rd(4'(ra[i]), v);
            chk($sformatf("R3 event %0d cleared", i), v, 0);
        end
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        pulse(4); pulse(5); pulse(10);
        rd(1, v); chk("R2 three events", v, 8'h86);
        wr(1, 8'h04);
        rd(1, v); chk("R3 partial clear", v, 8'h82);
        wr(1, 8'h00);
        rd(1, v); chk("R3 zero write keeps", v, 8'h82);
        wr(1, 8'hFF);
        rd(1, v); chk("R3 full clear", v, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        @(negedge clk);
        bus_we = 1; bus_addr = 1; bus_wdata = 8'h02; ev[4] = 1'b1;
        @(negedge clk);
        bus_we = 0; ev = '0;
        rd(1, v); chk("R4 event beats clear", v, 8'h02);
        wr(1, 8'hFF);
    endtask

    task automatic t_levels();
        logic [7:0] v;
        @(negedge clk); pin_wp = 1;
        @(negedge clk); rd(0, v); chk("R5 wp after one edge", v, 8'h00);
        // second edge coincides with a full clear of status A
        bus_we = 1; bus_addr = 0; bus_wdata = 8'hFF;
        @(negedge clk); bus_we = 0;
        rd(0, v); chk("R5 wp after two edges, clear ignored", v, 8'h02);
        @(negedge clk); pin_cd_dat3 = 1;
        repeat (2) @(negedge clk);
        rd(0, v); chk("R5 dat3 level", v, 8'h06);
        pin_wp = 0; pin_cd_dat3 = 0;
        repeat (3) @(negedge clk);
        rd(0, v); chk("R5 levels dropped", v, 8'h00);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        wr(4, 8'hFF); rd(4, v); chk("R6 mask A writable bits", v, 8'hF0);
        wr(5, 8'hFF); rd(5, v); chk("R6 mask B writable bits", v, 8'hFE);
        wr(4, 8'h00); wr(5, 8'h00);
    endtask

    task automatic t_irq();
        pulse(5);
        wr(5, 8'h04);
        chk("R7 no irq without global enable", irq, 0);
        wr(9, 8'h80);
        chk("R7 irq raised", irq, 1);
        wr(5, 8'h02);
        chk("R7 unmasked bit no irq", irq, 0);
        wr(1, 8'hFF);
        pulse(3);
        wr(5, 8'hFF);
        chk("R7 sdio bit never interrupts", irq, 0);
        pulse(0);
        wr(4, 8'h10);
        chk("R7 status A masked bit", irq, 1);
        wr(0, 8'hFF); wr(1, 8'hFF);
        chk("R7 irq falls after clear", irq, 0);
        wr(4, 8'h00); wr(5, 8'h00); wr(9, 8'h00);
    endtask

    task automatic t_cfg();
        logic [7:0] v;
        wr(8, 8'hA5); wr(9, 8'h0E);
        chk("R8 block length", blk_len_m1, 11'h6A5);
        chk("R8 crc abort", crc_abort_en, 1);
        rd(8, v); chk("R8 cfg low readback", v, 8'hA5);
        rd(9, v); chk("R8 cfg high readback", v, 8'h0E);
        wr(8, 8'h00); wr(9, 8'h00);
        chk("R8 crc abort off", crc_abort_en, 0);
    endtask

    task automatic t_stc();
        logic [7:0] v;
        @(negedge clk); cmd_busy = 1;
        rd(2, v); chk("R9 cmd busy", v, 8'h10);
        cmd_busy = 0; data_busy = 1;
        rd(2, v); chk("R9 data busy", v, 8'h20);
        wr(2, 8'hFF);
        rd(2, v); chk("R9 freeze and busy", v, 8'hA0);
        chk("R9 freeze output", clk_freeze_en, 1);
        data_busy = 0;
        wr(2, 8'h00);
        chk("R9 freeze off", clk_freeze_en, 0);
    endtask

    task automatic t_cd();
        logic [7:0] v;
        wr(9, 8'h30);           // GPI select, active-high
        wr(0, 8'hFF);
        chk("R11 absent active-high", card_present, 0);
        @(negedge clk); pin_cd_gpi = 1;
        repeat (2) @(negedge clk);
        rd(0, v); chk("R10 level seen, change not yet", v, 8'h08);
        chk("R11 present active-high", card_present, 1);
        @(negedge clk);
        rd(0, v); chk("R10 rising edge change", v, 8'h48);
        wr(0, 8'hFF);
        @(negedge clk); pin_cd_gpi = 0;
        repeat (3) @(negedge clk);
        rd(0, v); chk("R10 falling edge change", v, 8'h40);
        wr(0, 8'hFF);
        @(negedge clk); pin_cd_dat3 = 1;
        repeat (4) @(negedge clk);
        rd(0, v); chk("R10 unselected source silent", v, 8'h04);
        wr(9, 8'h20);           // GPI select, active-low
        chk("R11 active-low inverts", card_present, 1);
        wr(9, 8'h60);           // both selects: GPI wins, level 0, active-low
        chk("R11 GPI priority", card_present, 1);
        wr(9, 8'h50);           // DATA3 only, active-high, level 1
        chk("R11 DATA3 selected", card_present, 1);
        wr(9, 8'h10);
        chk("R11 no source", card_present, 0);
        pin_cd_dat3 = 0;
        repeat (3) @(negedge clk);
        wr(0, 8'hFF); wr(9, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_collision();
        t_levels();
        t_masks();
        t_irq();
        t_cfg();
        t_stc();
        t_cd();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule